// File: doc/BRIEF.md
# Boot-Sector Flash Command Controller

This block models the control side of a parallel NOR flash device, with the storage array held in registers inside it. It watches active-low chip-enable, write-enable and output-enable strobes and decodes multi-write command sequences into word programs, chip erases, multi-sector erases, erase suspend and erase resume. Program and erase durations come from cycle counters, so a testbench can use short values. While an operation runs, the ready output is low and reads return a status word instead of array data.

A write is recognised on the clock after the combined enable/write strobe falls. A read is recognised the same way on the combined enable/output strobe, and its value is latched one clock later. The unlock writes use two fixed word addresses: `UNLK_A` (default 5) and `UNLK_B` (default 10). Command codes sit in the low data byte. A fast program mode removes the two unlock writes from each program. A protect input per sector blocks programs and erases to that sector.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: The sequence 0xAA@UNLK_A, 0x55@UNLK_B, 0xA0@UNLK_A, then data@target programs the target word. The stored value becomes old AND new, so bits only go from 1 to 0.
- R2: 0xAA@UNLK_A, 0x55@UNLK_B, 0x20@UNLK_A enters fast program mode. In this mode, 0xA0 followed by data programs a word. 0x90 followed by 0x00 leaves the mode. After that, a lone 0xA0 and data write changes nothing.
- R3: A read during a busy operation returns status: bits 15:8 and 5:0 are zero, bit 7 is the complement of the target's bit 7, and bit 6 flips between successive reads.
- R4: Ready is low for exactly PROG_CYC clocks after the program data write, counting the clock of that write. The block then returns to array read.
- R5: The erase sequence 0xAA, 0x55, 0x80, 0xAA, 0x55 followed by 0x10@UNLK_A sets every unprotected word to 0xFFFF. Ready is low for PRE_CYC+ERS_CYC clocks: a preprogram-to-zero phase, then an erase-to-one phase.
- R6: Ending the erase sequence with 0x30 at an address in a sector opens a window of WIN_CYC clocks. Further 0x30 writes during the window add their sectors to the erase. Ready is low for WIN_CYC+PRE_CYC+ERS_CYC clocks, and sectors not chosen keep their data.
- R7: Writing 0xB0 during an erase raises ready on the next clock. While suspended, reads of other sectors return array data and programs to them run, and reads of an erasing sector return status with bit 6 held. Writing 0x30 resumes the remaining erase time.
- R8: A program to a protected sector leaves the data unchanged and ready high. An erase skips protected sectors.
- R9: A write that does not fit the sequence in progress discards it and returns the block to array read.
- R10: Reset aborts any operation, sets ready high and returns to array read. An aborted program leaves its target word unchanged.
- R11: With byte_n low, a_lsb selects the byte: 0 selects the low byte and 1 the high byte. Reads return that byte in bits 7:0 with bits 15:8 zero, and a program changes only that byte.
- R12: A read returns data one clock after the strobe. The output is zero when no read is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset and abort |
| ce_n | input | 1 | Active-low chip enable |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output strobe |
| byte_n | input | 1 | High selects 16-bit data, low selects 8-bit data |
| a_lsb | input | 1 | Byte select in 8-bit mode |
| addr | input | AW | Word address; upper bits pick the sector |
| din | input | 16 | Write data and command code |
| sect_prot | input | NSECT | Per-sector protect |
| dout | output | 16 | Read data or status |
| ready | output | 1 | High when no program or erase is running |

## Verification
A wrong sequence state either programs data that should be ignored or ignores a valid program. Either fault appears in the next read of the target word, so the bench reads back every word after each operation. A counter fault changes how many clocks ready stays low, and the bench measures that count exactly for each operation. A toggle or suspend fault shows within two status reads.

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl #(
  parameter int NSECT      = 4,
  parameter int SECT_WORDS = 4,
  parameter int PROG_CYC   = 12,
  parameter int PRE_CYC    = 10,
  parameter int ERS_CYC    = 20,
  parameter int WIN_CYC    = 16,
  parameter int UNLK_A     = 5,
  parameter int UNLK_B     = 10,
  localparam int AW = $clog2(NSECT * SECT_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic             byte_n,
  input  logic             a_lsb,
  input  logic [AW-1:0]    addr,
  input  logic [15:0]      din,
  input  logic [NSECT-1:0] sect_prot,
  output logic [15:0]      dout,
  output logic             ready
);
  localparam int NW = NSECT * SECT_WORDS;
  localparam int SB = $clog2(SECT_WORDS);
  localparam int SN = $clog2(NSECT);
  localparam int PW = $clog2(PROG_CYC + 1);
  localparam int EW = $clog2(PRE_CYC + ERS_CYC + WIN_CYC + 1);
  localparam logic [AW-1:0] UA = AW'(UNLK_A);
  localparam logic [AW-1:0] UB = AW'(UNLK_B);

  typedef enum logic [3:0] {
    S_RD, S_C1, S_C2, S_PD, S_E1, S_E2, S_E3, S_EW, S_PB, S_EB, S_BX
  } st_t;

  st_t              st;
  logic             byp, susp, ph, tog, tgt7, wr_q, rd_q;
  logic [PW-1:0]    pcnt;
  logic [EW-1:0]    ecnt;
  logic [NSECT-1:0] esect;
  logic [AW-1:0]    pa;
  logic [15:0]      pd;
  logic [15:0]      mem [NW];

  wire             wr_go = !ce_n && !we_n && wr_q;
  wire             rd_go = !ce_n && !oe_n && rd_q;
  wire [7:0]       cmd   = din[7:0];
  wire [SN-1:0]    asec  = addr[AW-1:SB];
  wire [NSECT-1:0] aone  = NSECT'(1) << asec;
  wire             busy  = (st == S_PB) || (st == S_EB) || (st == S_EW);
  wire             sus_hit = susp && esect[asec];
  wire [15:0]      wval  = byte_n ? din : (a_lsb ? {din[7:0], 8'hFF} : {8'hFF, din[7:0]});
  wire [15:0]      rword = mem[addr];
  wire [15:0]      rsel  = byte_n ? rword : {8'h00, a_lsb ? rword[15:8] : rword[7:0]};
  wire             tog_n = busy ? ~tog : tog;
  wire [15:0]      stat  = {8'h00, ~tgt7, tog_n, 6'b0};
  wire [NSECT-1:0] eadd  = (wr_go && cmd == 8'h30) ? (aone & ~sect_prot) : '0;
  wire             prg_tick = (st == S_PB) && (pcnt == '0);
  wire             ers_tick = (st == S_EB) && (ecnt == '0) && !(wr_go && cmd == 8'hB0);

  assign ready = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_RD; byp <= 1'b0; susp <= 1'b0; ph <= 1'b0; tog <= 1'b0; tgt7 <= 1'b0;
      wr_q <= 1'b1; rd_q <= 1'b1; pcnt <= '0; ecnt <= '0; esect <= '0;
      pa <= '0; pd <= '0; dout <= '0;
    end else begin
      wr_q <= ce_n || we_n;
      rd_q <= ce_n || oe_n;
      if (rd_go) begin
        dout <= (busy || sus_hit) ? stat : rsel;
        tog  <= tog_n;
      end else if (ce_n || oe_n) begin
        dout <= '0;
      end
      case (st)
        S_RD: if (wr_go) begin
          if (byp) begin
            if (cmd == 8'hA0) st <= S_PD;
            else if (cmd == 8'h90) st <= S_BX;
          end else if (susp && cmd == 8'h30) begin
            susp <= 1'b0;
            st   <= S_EB;
          end else if (cmd == 8'hAA && addr == UA) begin
            st <= S_C1;
          end
        end
        S_C1: if (wr_go) st <= (cmd == 8'h55 && addr == UB) ? S_C2 : S_RD;
        S_C2: if (wr_go) begin
          st <= S_RD;
          if (addr == UA) begin
            if (cmd == 8'hA0) st <= S_PD;
            else if (cmd == 8'h80 && !susp) st <= S_E1;
            else if (cmd == 8'h20 && !susp) byp <= 1'b1;
          end
        end
        S_PD: if (wr_go) begin
          if (sect_prot[asec] || sus_hit) begin
            st <= S_RD;
          end else begin
            pa   <= addr;
            pd   <= wval;
            tgt7 <= din[7];
            pcnt <= PW'(PROG_CYC - 1);
            st   <= S_PB;
          end
        end
        S_E1: if (wr_go) st <= (cmd == 8'hAA && addr == UA) ? S_E2 : S_RD;
        S_E2: if (wr_go) st <= (cmd == 8'h55 && addr == UB) ? S_E3 : S_RD;
        S_E3: if (wr_go) begin
          tgt7 <= 1'b1;
          ph   <= 1'b0;
          if (cmd == 8'h10 && addr == UA) begin
            esect <= ~sect_prot;
            ecnt  <= EW'(PRE_CYC - 1);
            st    <= (&sect_prot) ? S_RD : S_EB;
          end else if (cmd == 8'h30) begin
            esect <= eadd;
            ecnt  <= EW'(WIN_CYC - 1);
            st    <= S_EW;
          end else begin
            st <= S_RD;
          end
        end
        S_EW: begin
          esect <= esect | eadd;
          if (ecnt == '0) begin
            ecnt <= EW'(PRE_CYC - 1);
            st   <= ((esect | eadd) == '0) ? S_RD : S_EB;
          end else begin
            ecnt <= ecnt - 1'b1;
          end
        end
        S_EB: begin
          if (wr_go && cmd == 8'hB0) begin
            susp <= 1'b1;
            st   <= S_RD;
          end else if (ecnt != '0) begin
            ecnt <= ecnt - 1'b1;
          end else if (!ph) begin
            ph   <= 1'b1;
            ecnt <= EW'(ERS_CYC - 1);
          end else begin
            esect <= '0;
            st    <= S_RD;
          end
        end
        S_PB: begin
          if (pcnt == '0) st <= S_RD;
          else pcnt <= pcnt - 1'b1;
        end
        S_BX: if (wr_go) begin
          if (cmd == 8'h00) byp <= 1'b0;
          st <= S_RD;
        end
        default: st <= S_RD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (prg_tick) mem[pa] <= mem[pa] & pd;
    if (ers_tick)
      for (int i = 0; i < NW; i++)
        if (esect[i / SECT_WORDS]) mem[i] <= ph ? 16'hFFFF : 16'h0000;
  end

  generate
    for (genvar g = 0; g < NW; g++) begin : g_chk
      a_r1_program_clears_only: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) != S_EB) |-> ((mem[g] & ~$past(mem[g])) == 16'h0000));
    end
  endgenerate

  a_r4_ready_after_program: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PB && pcnt == '0) |=> ready);
  a_r7_suspend_freezes_erase: assert property (@(posedge clk) disable iff (!rst_n)
    (susp && $past(susp)) |-> $stable(ecnt));
  a_r2_bypass_persists: assert property (@(posedge clk) disable iff (!rst_n)
    (byp && st == S_PB) |=> byp);
endmodule

// File: tb/tb_nor_cmd_ctrl.sv
module tb_nor_cmd_ctrl;
  localparam int PROG = 12, PRE = 10, ERS = 20, WIN = 16;
  logic clk = 0, rst_n = 0, ce_n = 1, we_n = 1, oe_n = 1, byte_n = 1, a_lsb = 0;
  logic [3:0] addr = 0;
  logic [15:0] din = 0;
  logic [3:0] sect_prot = 0;
  logic [15:0] dout;
  logic ready;
  logic [15:0] m [16];
  int checks = 0, errors = 0;

  nor_cmd_ctrl #(.NSECT(4), .SECT_WORDS(4), .PROG_CYC(PROG), .PRE_CYC(PRE),
    .ERS_CYC(ERS), .WIN_CYC(WIN), .UNLK_A(5), .UNLK_B(10)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .byte_n(byte_n), .a_lsb(a_lsb), .addr(addr), .din(din),
    .sect_prot(sect_prot), .dout(dout), .ready(ready));

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %h exp %h", tag, act, exp);
    end
  endtask

  task automatic bw(input logic [3:0] a, input logic [15:0] d);
    ce_n = 0; we_n = 0; addr = a; din = d;
    @(negedge clk); we_n = 1; ce_n = 1;
    @(negedge clk);
  endtask

  task automatic br(input logic [3:0] a, output logic [15:0] q);
    ce_n = 0; oe_n = 0; addr = a;
    @(negedge clk); q = dout; oe_n = 1; ce_n = 1;
    @(negedge clk);
  endtask

  task automatic waitrdy(output int n);
    n = 0;
    while (!ready && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic prog(input logic [3:0] a, input logic [15:0] d);
    bw(5, 16'hAA); bw(10, 16'h55); bw(5, 16'hA0); bw(a, d);
  endtask

  task automatic erase_pre();
    bw(5, 16'hAA); bw(10, 16'h55); bw(5, 16'h80); bw(5, 16'hAA); bw(10, 16'h55);
  endtask

  task automatic sweep(input string tag);
    logic [15:0] q;
    for (int i = 0; i < 16; i++) begin
      br(4'(i), q);
      chk(tag, q, m[i]);
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog act timeout exp finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] q, q2;
    int n;
    repeat (3) @(negedge clk);
    chk("R10 reset ready", ready, 1);
    chk("R12 idle dout", dout, 0);
    rst_n = 1;
    @(negedge clk);

    erase_pre(); bw(5, 16'h10);
    waitrdy(n);
    chk("R5 chip erase cycles", 1 + n, PRE + ERS);
    for (int i = 0; i < 16; i++) m[i] = 16'hFFFF;
    sweep("R5 erased");
    chk("R12 dout idle after read", dout, 0);

    for (int i = 0; i < 16; i++) begin
      logic [15:0] p;
      p = ~(16'h1 << i) & (16'hFFFF ^ 16'(i * 16'h0F11));
      prog(4'(i), p);
      waitrdy(n);
      if (i == 0) chk("R4 program cycles", 1 + n, PROG);
      m[i] &= p;
    end
    sweep("R1 program sweep");
    prog(3, 16'h5A5A); waitrdy(n); m[3] &= 16'h5A5A;
    br(3, q); chk("R1 and-merge", q, m[3]);

    prog(5, 16'hFF80);
    br(5, q); br(5, q2);
    chk("R3 status bit7", q[7], 0);
    chk("R3 status zero bits", {q[15:8], q[5:0]}, 0);
    chk("R3 toggle", q[6] ^ q2[6], 1);
    waitrdy(n); m[5] &= 16'hFF80;
    br(5, q); chk("R4 array read after program", q, m[5]);

    bw(5, 16'hAA); bw(10, 16'h55); bw(5, 16'h20);
    for (int i = 0; i < 4; i++) begin
      bw(5, 16'hA0); bw(4'(i), 16'h0F0F >> i);
      waitrdy(n); m[i] &= 16'h0F0F >> i;
    end
    bw(0, 16'h90); bw(0, 16'h00);
    bw(5, 16'hA0); bw(8, 16'h0000);
    chk("R2 exit no busy", ready, 1);
    sweep("R2 bypass result");

    bw(5, 16'hAA); bw(10, 16'h55); bw(5, 16'h77); bw(9, 16'h0000);
    chk("R9 abort ready", ready, 1);
    bw(5, 16'hAA); bw(3, 16'h55); bw(5, 16'hA0); bw(9, 16'h0000);
    chk("R9 wrong addr ready", ready, 1);
    br(9, q); chk("R9 word kept", q, m[9]);

    sect_prot = 4'b0010;
    prog(4, 16'h0000);
    chk("R8 protected no busy", ready, 1);
    br(4, q); chk("R8 protected kept", q, m[4]);
    erase_pre(); bw(8, 16'h30); bw(4, 16'h30); bw(12, 16'h30);
    waitrdy(n);
    chk("R6 window erase cycles", 1 + 4 + n, WIN + PRE + ERS);
    for (int i = 8; i < 16; i++) m[i] = 16'hFFFF;
    sweep("R6 R8 sector erase");
    erase_pre(); bw(5, 16'h10); waitrdy(n);
    for (int i = 0; i < 16; i++) if (i < 4 || i > 7) m[i] = 16'hFFFF;
    sweep("R8 chip erase skips protected");
    sect_prot = 0;

    prog(0, 16'h1234); waitrdy(n); m[0] &= 16'h1234;
    prog(8, 16'h4321); waitrdy(n); m[8] &= 16'h4321;
    erase_pre(); bw(0, 16'h30);
    repeat (WIN + 4) @(negedge clk);
    bw(0, 16'hB0);
    chk("R7 ready after suspend", ready, 1);
    br(0, q); br(0, q2);
    chk("R7 erasing sector status", q[7], 0);
    chk("R7 toggle held", q[6] ^ q2[6], 0);
    br(8, q); chk("R7 other sector read", q, m[8]);
    prog(9, 16'h00FF); waitrdy(n); m[9] &= 16'h00FF;
    br(9, q); chk("R7 program in suspend", q, m[9]);
    prog(1, 16'h0000);
    chk("R7 erasing sector program ignored", ready, 1);
    bw(0, 16'h30);
    chk("R7 resume busy", ready, 0);
    waitrdy(n);
    for (int i = 0; i < 4; i++) m[i] = 16'hFFFF;
    sweep("R7 resumed erase");

    byte_n = 0; a_lsb = 1;
    prog(10, 16'h003C); waitrdy(n); m[10] &= 16'h3CFF;
    br(10, q); chk("R11 high byte", q, {8'h00, m[10][15:8]});
    a_lsb = 0;
    br(10, q); chk("R11 low byte", q, {8'h00, m[10][7:0]});
    byte_n = 1;
    br(10, q); chk("R11 word view", q, m[10]);

    prog(11, 16'h0000);
    repeat (3) @(negedge clk);
    rst_n = 0; repeat (2) @(negedge clk);
    chk("R10 abort ready", ready, 1);
    rst_n = 1; @(negedge clk);
    br(11, q); chk("R10 aborted word kept", q, m[11]);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule